// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside the CPU of a small 16-bit microcontroller and chooses which handler runs next. It sorts requests into three classes: reset events, which need no enable; non-maskable events, each gated only by its own enable bit; and maskable events, which need their own enable bit and the global interrupt enable. Every class maps to a word-aligned vector slot at the top of the address map. Slot n lives at FFC0h + 2·n. The reset slot (31, FFFEh) has the highest priority, the non-maskable slot (30, FFFCh) comes next, and the maskable slots fill 16 upward to 29 (FFE0h to FFFAh). A higher slot number always wins. Slots 0 to 15 carry no source.

The winning vector is latched and presented with a request strobe. It stays unchanged until the CPU acknowledges. The acknowledge also clears the global enable, so software must set it again before the next maskable request. The block also watches instruction fetch addresses. A fetch from the peripheral register space or from an unmapped gap raises an internal reset. After power-up it inspects the first word read from the reset slot: an erased value makes it ask for the deepest low-power mode. A sticky cause register records which reset sources have fired, and software clears it bit by bit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `irq_req_o`=0, `gie_o`=0, `lpm_req_o`=0 and `cause_o`=5'b00001 (bit 0 = power-up). One clock after release, `irq_req_o`=1 with `vec_addr_o`=FFFEh.
- R2: A pulse on `rst_src_i` (bit 0 external pin, bit 1 watchdog, bit 2 key violation) sets cause bit 1, 2 or 3 on the next edge and creates a pending reset request. Neither needs an enable. The reset request wins over any pending non-maskable or maskable source and is cleared only by an acknowledge of the reset slot.
- R3: Non-maskable source i is accepted when `nmi_flag_i[i]` and `nmi_en_i[i]` are both 1, whatever `gie_o` is. It gives vector FFFCh. With its enable at 0 it gives no request.
- R4: Maskable source k is accepted only when `mask_flag_i[k]`, `mask_en_i[k]` and `gie_o` are all 1. Its vector is FFE0h + 2·k. Among accepted sources the highest k wins.
- R5: An accepted non-maskable source wins over every maskable source.
- R6: In the idle state an accepted request is latched on a clock edge, and `irq_req_o` rises after that edge. While `irq_req_o`=1 and `ack_i`=0, `vec_addr_o` does not change, even if a higher-priority request arrives. `irq_req_o` falls on the edge where `ack_i`=1. `vec_addr_o` reads 0000h when no request is shown.
- R7: A `gie_set_i` pulse sets `gie_o` on the next edge. An acknowledge or any reset event clears it on that edge.
- R8: A fetch (`fetch_valid_i`=1) from 0000h–01FFh, or from `RAM_END`+1 to `FLASH_BASE`−1, drives `sys_rst_o` high for one cycle after the edge, sets cause bit 4 and creates a pending reset request. Fetches from 0200h–`RAM_END` or from `FLASH_BASE` upward do nothing.
- R9: After power-up, the first `boot_valid_i` word is checked. If it is FFFFh, `lpm_req_o` goes high on the next edge and stays high until `rst`. Any later boot word has no effect.
- R10: While `irq_req_o`=1, `vec_addr_o` is even and not below FFE0h.
- R11: A bit of `cause_clr_i` clears that cause bit on the next edge. A new event of the same cause in the same cycle keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rst_src_i | input | 3 | Reset sources: external pin, watchdog, key violation |
| nmi_flag_i | input | NUM_NMI | Non-maskable source flags |
| nmi_en_i | input | NUM_NMI | Per-source non-maskable enables |
| mask_flag_i | input | NUM_MASK | Maskable source flags, index k maps to slot 16+k |
| mask_en_i | input | NUM_MASK | Per-source maskable enables |
| gie_set_i | input | 1 | Software pulse that sets the global enable |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 16 | Instruction fetch address |
| boot_valid_i | input | 1 | Strobe for a word read from the reset slot |
| boot_word_i | input | 16 | Word read from the reset slot |
| ack_i | input | 1 | CPU acknowledge of the shown vector |
| cause_clr_i | input | 5 | Per-bit clear of the sticky cause register |
| irq_req_o | output | 1 | Vector request to the CPU |
| vec_addr_o | output | 16 | Word address of the winning vector slot |
| lpm_req_o | output | 1 | Request for the deepest low-power mode |
| sys_rst_o | output | 1 | One-cycle internal reset from an illegal fetch |
| gie_o | output | 1 | Global interrupt enable |
| cause_o | output | 5 | Sticky reset causes: power-up, pin, watchdog, key, fetch range |

## Verification
The hardest case to reach is a latched vector that must hold while a stronger request appears behind it. The stimulus first sets the global enable and lets a maskable source be latched. It then raises a non-maskable source while the request is still unacknowledged, checks that the vector is unchanged, and checks that the non-maskable vector follows only after the acknowledge. A second hard case is a reset that becomes pending one cycle before other sources arrive. Pulsing a watchdog reset with all flags quiet and raising a non-maskable flag on the next cycle lets both be seen by the arbiter on the same edge. A seeded random loop then covers mixtures of flags, enables and global enable, and checks them against a bench model of the priority order.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int          ADDR_W      = 16;
    localparam int          SLOT_W      = 5;
    localparam int          CAUSE_W     = 5;
    localparam int          RST_SRC_W   = 3;
    localparam int          MASK_MAX    = 14;

    localparam logic [ADDR_W-1:0] VEC_BASE    = 16'hFFC0;
    localparam logic [ADDR_W-1:0] PERIPH_TOP  = 16'h01FF;
    localparam logic [ADDR_W-1:0] ERASED_WORD = 16'hFFFF;

    localparam logic [SLOT_W-1:0] SLOT_RESET     = 5'd31;
    localparam logic [SLOT_W-1:0] SLOT_NMI       = 5'd30;
    localparam logic [SLOT_W-1:0] SLOT_MASK_BASE = 5'd16;

    // cause register bit positions
    localparam int C_POWER = 0;
    localparam int C_PIN   = 1;
    localparam int C_WDOG  = 2;
    localparam int C_KEY   = 3;
    localparam int C_FETCH = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_AT_POWERUP = 5'b00001;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_MASK  = 2'd1,
        CLS_NMI   = 2'd2,
        CLS_RESET = 2'd3
    } irq_cls_e;

    typedef struct packed {
        logic              valid;
        irq_cls_e          cls;
        logic [SLOT_W-1:0] slot;
    } irq_win_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } hs_state_e;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
        return VEC_BASE + {{(ADDR_W-SLOT_W-1){1'b0}}, s, 1'b0};
    endfunction

endpackage

// File: rtl/irqv_fetch_guard.sv
module irqv_fetch_guard
    import irqv_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_END    = 16'h0BFF,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h2100
) (
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              illegal_o
);

    logic in_ram;
    logic in_flash;

    always_comb begin
        in_ram    = (fetch_addr_i > PERIPH_TOP) && (fetch_addr_i <= RAM_END);
        in_flash  = (fetch_addr_i >= FLASH_BASE);
        illegal_o = fetch_valid_i && !(in_ram || in_flash);
    end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int NUM_NMI  = 3,
    parameter int NUM_MASK = 14
) (
    input  logic                rst_pend_i,
    input  logic [NUM_NMI-1:0]  nmi_flag_i,
    input  logic [NUM_NMI-1:0]  nmi_en_i,
    input  logic [NUM_MASK-1:0] mask_flag_i,
    input  logic [NUM_MASK-1:0] mask_en_i,
    input  logic                gie_i,
    output irq_win_t            win_o
);

    logic [NUM_MASK-1:0] mask_acc;
    logic                nmi_acc;

    genvar k;
    generate
        for (k = 0; k < NUM_MASK; k++) begin : g_mask_gate
            assign mask_acc[k] = mask_flag_i[k] & mask_en_i[k] & gie_i;
        end
    endgenerate

    assign nmi_acc = |(nmi_flag_i & nmi_en_i);

    always_comb begin
        win_o = '{valid: 1'b0, cls: CLS_NONE, slot: '0};
        // ascending scan: the last hit is the highest slot
        for (int i = 0; i < NUM_MASK; i++) begin
            if (mask_acc[i]) begin
                win_o.valid = 1'b1;
                win_o.cls   = CLS_MASK;
                win_o.slot  = SLOT_MASK_BASE + SLOT_W'(i);
            end
        end
        if (nmi_acc) begin
            win_o.valid = 1'b1;
            win_o.cls   = CLS_NMI;
            win_o.slot  = SLOT_NMI;
        end
        if (rst_pend_i) begin
            win_o.valid = 1'b1;
            win_o.cls   = CLS_RESET;
            win_o.slot  = SLOT_RESET;
        end
    end

endmodule

// File: rtl/irqv_reset_unit.sv
module irqv_reset_unit
    import irqv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RST_SRC_W-1:0] ext_src_i,
    input  logic                 fetch_bad_i,
    input  logic                 ack_rst_i,
    input  logic [CAUSE_W-1:0]   cause_clr_i,
    input  logic                 boot_valid_i,
    input  logic [ADDR_W-1:0]    boot_word_i,
    output logic                 rst_pend_o,
    output logic                 event_o,
    output logic                 sys_rst_o,
    output logic [CAUSE_W-1:0]   cause_o,
    output logic                 lpm_o
);

    logic [CAUSE_W-1:0] new_bits;
    logic               boot_open;

    always_comb begin
        new_bits          = '0;
        new_bits[C_PIN]   = ext_src_i[0];
        new_bits[C_WDOG]  = ext_src_i[1];
        new_bits[C_KEY]   = ext_src_i[2];
        new_bits[C_FETCH] = fetch_bad_i;
        event_o           = |new_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_o    <= CAUSE_AT_POWERUP;
            rst_pend_o <= 1'b1;
            sys_rst_o  <= 1'b0;
            boot_open  <= 1'b1;
            lpm_o      <= 1'b0;
        end else begin
            cause_o   <= (cause_o & ~cause_clr_i) | new_bits;
            sys_rst_o <= fetch_bad_i;
            if (event_o) begin
                rst_pend_o <= 1'b1;
            end else if (ack_rst_i) begin
                rst_pend_o <= 1'b0;
            end
            if (boot_valid_i) begin
                boot_open <= 1'b0;
                if (boot_open && boot_word_i == ERASED_WORD) begin
                    lpm_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int                NUM_NMI    = 3,
    parameter int                NUM_MASK   = 14,
    parameter logic [ADDR_W-1:0] RAM_END    = 16'h0BFF,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h2100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RST_SRC_W-1:0] rst_src_i,
    input  logic [NUM_NMI-1:0]   nmi_flag_i,
    input  logic [NUM_NMI-1:0]   nmi_en_i,
    input  logic [NUM_MASK-1:0]  mask_flag_i,
    input  logic [NUM_MASK-1:0]  mask_en_i,
    input  logic                 gie_set_i,
    input  logic                 fetch_valid_i,
    input  logic [ADDR_W-1:0]    fetch_addr_i,
    input  logic                 boot_valid_i,
    input  logic [ADDR_W-1:0]    boot_word_i,
    input  logic                 ack_i,
    input  logic [CAUSE_W-1:0]   cause_clr_i,
    output logic                 irq_req_o,
    output logic [ADDR_W-1:0]    vec_addr_o,
    output logic                 lpm_req_o,
    output logic                 sys_rst_o,
    output logic                 gie_o,
    output logic [CAUSE_W-1:0]   cause_o
);

    hs_state_e state;
    irq_win_t  held;
    irq_win_t  win;
    logic      fetch_bad;
    logic      rst_pend;
    logic      rst_event;
    logic      ack_fire;
    logic      ack_rst;

    assign ack_fire = (state == ST_REQ) && ack_i;
    assign ack_rst  = ack_fire && (held.cls == CLS_RESET);

    irqv_fetch_guard #(
        .RAM_END    (RAM_END),
        .FLASH_BASE (FLASH_BASE)
    ) u_guard (
        .fetch_valid_i (fetch_valid_i),
        .fetch_addr_i  (fetch_addr_i),
        .illegal_o     (fetch_bad)
    );

    irqv_reset_unit u_rstu (
        .clk          (clk),
        .rst          (rst),
        .ext_src_i    (rst_src_i),
        .fetch_bad_i  (fetch_bad),
        .ack_rst_i    (ack_rst),
        .cause_clr_i  (cause_clr_i),
        .boot_valid_i (boot_valid_i),
        .boot_word_i  (boot_word_i),
        .rst_pend_o   (rst_pend),
        .event_o      (rst_event),
        .sys_rst_o    (sys_rst_o),
        .cause_o      (cause_o),
        .lpm_o        (lpm_req_o)
    );

    irqv_arbiter #(
        .NUM_NMI  (NUM_NMI),
        .NUM_MASK (NUM_MASK)
    ) u_arb (
        .rst_pend_i  (rst_pend),
        .nmi_flag_i  (nmi_flag_i),
        .nmi_en_i    (nmi_en_i),
        .mask_flag_i (mask_flag_i),
        .mask_en_i   (mask_en_i),
        .gie_i       (gie_o),
        .win_o       (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= '{valid: 1'b0, cls: CLS_NONE, slot: '0};
        end else begin
            case (state)
                ST_IDLE: begin
                    if (win.valid) begin
                        state <= ST_REQ;
                        held  <= win;
                    end
                end
                ST_REQ: begin
                    if (ack_i) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_o <= 1'b0;
        end else if (rst_event || ack_fire) begin
            gie_o <= 1'b0;
        end else if (gie_set_i) begin
            gie_o <= 1'b1;
        end
    end

    assign irq_req_o  = (state == ST_REQ);
    assign vec_addr_o = (state == ST_REQ) ? slot_addr(held.slot) : '0;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter logic [15:0] RAM_END    = 16'h0BFF,
    parameter logic [15:0] FLASH_BASE = 16'h2100
) (
    input logic        clk,
    input logic        rst,
    input logic        ack_i,
    input logic        fetch_valid_i,
    input logic [15:0] fetch_addr_i,
    input logic        irq_req_o,
    input logic [15:0] vec_addr_o,
    input logic        lpm_req_o,
    input logic        sys_rst_o,
    input logic        gie_o,
    input logic [4:0]  cause_o
);

    logic bad_fetch;
    assign bad_fetch = fetch_valid_i &&
                       ((fetch_addr_i < 16'h0200) ||
                        (fetch_addr_i > RAM_END && fetch_addr_i < FLASH_BASE));

    // R6
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && !ack_i) |=> (irq_req_o && $stable(vec_addr_o)));

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && ack_i) |=> !irq_req_o);

    // R10
    slot_floor_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (vec_addr_o >= 16'hFFE0 && !vec_addr_o[0]));

    // R7
    gie_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && ack_i) |=> !gie_o);

    // R8
    fetch_rst_chk: assert property (@(posedge clk) disable iff (rst)
        bad_fetch |=> (sys_rst_o && cause_o[4]));

    // R9
    lpm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lpm_req_o |=> lpm_req_o);

    // R4
    mask_gie_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_req_o) && vec_addr_o < 16'hFFFC) |-> $past(gie_o));

endmodule

bind irq_vector_ctrl irqv_checker #(
    .RAM_END    (RAM_END),
    .FLASH_BASE (FLASH_BASE)
) u_irqv_chk (
    .clk           (clk),
    .rst           (rst),
    .ack_i         (ack_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .irq_req_o     (irq_req_o),
    .vec_addr_o    (vec_addr_o),
    .lpm_req_o     (lpm_req_o),
    .sys_rst_o     (sys_rst_o),
    .gie_o         (gie_o),
    .cause_o       (cause_o)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NN = 3;
    localparam int NM = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    rst_src_i = '0;
    logic [NN-1:0] nmi_flag_i = '0;
    logic [NN-1:0] nmi_en_i = '0;
    logic [NM-1:0] mask_flag_i = '0;
    logic [NM-1:0] mask_en_i = '0;
    logic          gie_set_i = 1'b0;
    logic          fetch_valid_i = 1'b0;
    logic [15:0]   fetch_addr_i = 16'hC000;
    logic          boot_valid_i = 1'b0;
    logic [15:0]   boot_word_i = '0;
    logic          ack_i = 1'b0;
    logic [4:0]    cause_clr_i = '0;
    logic          irq_req_o;
    logic [15:0]   vec_addr_o;
    logic          lpm_req_o;
    logic          sys_rst_o;
    logic          gie_o;
    logic [4:0]    cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst(rst), .rst_src_i(rst_src_i),
        .nmi_flag_i(nmi_flag_i), .nmi_en_i(nmi_en_i),
        .mask_flag_i(mask_flag_i), .mask_en_i(mask_en_i),
        .gie_set_i(gie_set_i), .fetch_valid_i(fetch_valid_i),
        .fetch_addr_i(fetch_addr_i), .boot_valid_i(boot_valid_i),
        .boot_word_i(boot_word_i), .ack_i(ack_i), .cause_clr_i(cause_clr_i),
        .irq_req_o(irq_req_o), .vec_addr_o(vec_addr_o), .lpm_req_o(lpm_req_o),
        .sys_rst_o(sys_rst_o), .gie_o(gie_o), .cause_o(cause_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model of the priority order: {valid, address}
    function automatic logic [16:0] model_vec(input logic [NN-1:0] nf, input logic [NN-1:0] ne,
                                              input logic [NM-1:0] mf, input logic [NM-1:0] me,
                                              input logic g);
        logic [16:0] r = '0;
        if (g) begin
            for (int k = 0; k < NM; k++)
                if (mf[k] && me[k]) r = {1'b1, 16'hFFE0 + 16'(2*k)};
        end
        if ((nf & ne) != '0) r = {1'b1, 16'hFFFC};
        return r;
    endfunction

    task automatic do_ack();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
    endtask

    task automatic fetch_at(input logic [15:0] a);
        fetch_valid_i = 1'b1;
        fetch_addr_i  = a;
        tick();
        fetch_valid_i = 1'b0;
        fetch_addr_i  = 16'hC000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic        m_gie;
        logic [16:0] e;
        seed_v = $urandom(32'd4242);

        // R1 reset state
        tick(); tick();
        chk("R1 req in reset", 16'(irq_req_o), 16'h0);
        chk("R1 cause in reset", 16'(cause_o), 16'h0001);
        chk("R1 gie in reset", 16'(gie_o), 16'h0);
        chk("R1 lpm in reset", 16'(lpm_req_o), 16'h0);
        rst = 1'b0;
        tick();
        chk("R1 reset slot req", 16'(irq_req_o), 16'h1);
        chk("R1 reset slot vec", vec_addr_o, 16'hFFFE);

        // R9 programmed boot word: no low-power request, later erased word ignored
        boot_valid_i = 1'b1; boot_word_i = 16'h8000;
        tick();
        boot_valid_i = 1'b0;
        chk("R9 programmed word", 16'(lpm_req_o), 16'h0);
        boot_valid_i = 1'b1; boot_word_i = 16'hFFFF;
        tick();
        boot_valid_i = 1'b0;
        chk("R9 late erased word", 16'(lpm_req_o), 16'h0);
        chk("R6 held reset vec", vec_addr_o, 16'hFFFE);
        do_ack();
        chk("R6 drop after ack", 16'(irq_req_o), 16'h0);
        chk("R6 idle vec zero", vec_addr_o, 16'h0000);

        // R4 maskable blocked without global enable; R3 nmi blocked by own enable
        mask_flag_i = 14'h0010; mask_en_i = 14'h3FFF;
        nmi_flag_i = 3'b010; nmi_en_i = 3'b101;
        tick(); tick();
        chk("R4 no gie no req", 16'(irq_req_o), 16'h0);
        chk("R3 nmi disabled no req", 16'(irq_req_o), 16'h0);
        nmi_flag_i = '0; mask_flag_i = '0;

        // R7 set gie; R4 maskable vector; R6 hold while nmi arrives
        gie_set_i = 1'b1;
        tick();
        gie_set_i = 1'b0;
        chk("R7 gie set", 16'(gie_o), 16'h1);
        mask_flag_i = 14'h0009; mask_en_i = 14'h0008;
        tick();
        chk("R4 slot k=3 vec", vec_addr_o, 16'hFFE6);
        nmi_flag_i = 3'b001; nmi_en_i = 3'b001;
        tick();
        chk("R6 hold vs nmi", vec_addr_o, 16'hFFE6);
        tick();
        chk("R6 hold vs nmi 2", vec_addr_o, 16'hFFE6);
        mask_flag_i = '0;
        do_ack();
        chk("R6 req low after ack", 16'(irq_req_o), 16'h0);
        chk("R7 gie cleared by ack", 16'(gie_o), 16'h0);
        tick();
        chk("R3 nmi without gie", vec_addr_o, 16'hFFFC);
        nmi_flag_i = '0;
        do_ack();

        // R5 nmi beats maskable; R4 highest maskable wins
        gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
        mask_flag_i = 14'h3FFF; mask_en_i = 14'h3FFF;
        nmi_flag_i = 3'b100; nmi_en_i = 3'b100;
        tick();
        chk("R5 nmi over maskable", vec_addr_o, 16'hFFFC);
        nmi_flag_i = '0; mask_flag_i = '0;
        do_ack();
        gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
        mask_flag_i = 14'h2001;
        tick();
        chk("R4 top maskable slot", vec_addr_o, 16'hFFFA);
        mask_flag_i = '0;
        do_ack();

        // R2 watchdog reset wins over nmi arriving one cycle later; no enable needed
        rst_src_i = 3'b010;
        tick();
        rst_src_i = '0;
        chk("R2 wdog cause", 16'(cause_o), 16'h0005);
        nmi_flag_i = 3'b001; nmi_en_i = 3'b001;
        tick();
        chk("R2 reset over nmi", vec_addr_o, 16'hFFFE);
        nmi_flag_i = '0;
        do_ack();
        tick();
        chk("R2 pending cleared by ack", 16'(irq_req_o), 16'h0);

        // R11 clearing causes, set wins over clear
        cause_clr_i = 5'b00101;
        tick();
        cause_clr_i = '0;
        chk("R11 cleared", 16'(cause_o), 16'h0000);
        rst_src_i = 3'b001; cause_clr_i = 5'b00010;
        tick();
        rst_src_i = '0; cause_clr_i = '0;
        chk("R11 set wins", 16'(cause_o), 16'h0002);
        tick();
        chk("R2 pin reset vec", vec_addr_o, 16'hFFFE);
        do_ack();
        cause_clr_i = 5'b11111; tick(); cause_clr_i = '0;

        // R8 fetch range
        fetch_at(16'h0200);
        chk("R8 legal 0200", 16'(sys_rst_o), 16'h0);
        fetch_at(16'h0BFF);
        chk("R8 legal ram top", 16'(sys_rst_o), 16'h0);
        fetch_at(16'h2100);
        chk("R8 legal flash base", 16'(sys_rst_o), 16'h0);
        chk("R8 no req after legal", 16'(irq_req_o), 16'h0);
        fetch_at(16'h01FF);
        chk("R8 periph fetch rst", 16'(sys_rst_o), 16'h1);
        chk("R8 cause bit4", 16'(cause_o), 16'h0010);
        tick();
        chk("R8 rst one cycle", 16'(sys_rst_o), 16'h0);
        chk("R8 reset vec", vec_addr_o, 16'hFFFE);
        do_ack();
        fetch_at(16'h0C00);
        chk("R8 gap low edge", 16'(sys_rst_o), 16'h1);
        tick();
        do_ack();
        fetch_at(16'h20FF);
        chk("R8 gap high edge", 16'(sys_rst_o), 16'h1);
        tick();
        do_ack();

        // R9 erased reset vector after power-up
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        tick();
        boot_valid_i = 1'b1; boot_word_i = 16'hFFFF;
        tick();
        boot_valid_i = 1'b0;
        chk("R9 erased word lpm", 16'(lpm_req_o), 16'h1);
        tick();
        chk("R9 lpm sticky", 16'(lpm_req_o), 16'h1);
        do_ack();

        // random mixtures against the bench model (R3 R4 R5 R7)
        m_gie = 1'b0;
        for (int it = 0; it < 60; it++) begin
            logic          g;
            logic [NN-1:0] nf;
            logic [NN-1:0] ne;
            logic [NM-1:0] mf;
            logic [NM-1:0] me;
            g  = 1'($urandom % 2);
            nf = ($urandom % 4 == 0) ? NN'($urandom) : '0;
            ne = NN'($urandom);
            mf = NM'($urandom);
            me = NM'($urandom);
            gie_set_i = g;
            tick();
            gie_set_i = 1'b0;
            m_gie = m_gie | g;
            chk("R7 random gie", 16'(gie_o), 16'(m_gie));
            nmi_flag_i = nf; nmi_en_i = ne; mask_flag_i = mf; mask_en_i = me;
            tick();
            e = model_vec(nf, ne, mf, me, m_gie);
            nmi_flag_i = '0; mask_flag_i = '0;
            chk("R4 R5 random req", 16'(irq_req_o), 16'(e[16]));
            if (e[16]) begin
                chk("R3 R4 R5 random vec", vec_addr_o, e[15:0]);
                do_ack();
                m_gie = 1'b0;
                chk("R6 random drop", 16'(irq_req_o), 16'h0);
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule